// File: doc/BRIEF.md
# Processor Reset Entry Sequencer

This block governs how a small 32-bit processor core enters and leaves reset. It owns the program counter, the status word and the two supervisor-bank registers (link and saved status). While the active-low reset input is low, the core abandons whatever it was doing. The fetch address keeps advancing by the current instruction width. The bus cycle outputs mark every cycle as internal, so memory sees no request.

On release, the reset input is first brought into the clock domain through a two-flop synchroniser. One banking cycle follows. In it, the address that was on the bus goes into the supervisor link register and the status word goes into the supervisor saved-status register. In the same cycle the low byte of the status word is forced to supervisor mode with both interrupt masks set and the 16-bit state flag cleared. The next cycle issues a non-sequential fetch from address zero. Sequential 32-bit fetching continues from there.

Between resets, an external write port stands in for the execute datapath. It loads a new PC and status word, which models a branch or a mode change. Writes are honoured only in the running phase. The status word, the supervisor link and the saved-status registers are also brought out as read-only observation outputs.

Top module: `boot_entry_seq`

## Requirements
- R1: While rst_ni is low, mreq_no is 1 and seq_o is 0 (internal cycle), with no clock edge needed.
- R2: While in reset with status bit 5 (16-bit state flag) clear, addr_o grows by 4 at every rising clock edge.
- R3: While in reset with status bit 5 set, addr_o grows by 2 at every rising clock edge.
- R4: After rst_ni rises, addr_o keeps growing at the first three rising edges. The cycle after the third edge is the banking cycle, with mreq_no=1 and seq_o=0.
- R5: At the end of the banking cycle, lr_svc_o takes the addr_o value shown during that cycle and spsr_svc_o takes the status word of that cycle.
- R6: At the end of the banking cycle, status bits [7:0] become 8'hD3 (bit 7 IRQ mask = 1, bit 6 FIQ mask = 1, bit 5 = 0, mode [4:0] = 5'b10011). Bits [31:8] are kept.
- R7: The cycle after the banking cycle is a fetch from address 0 with mreq_no=0 and seq_o=0.
- R8: After that first fetch, and while no write is accepted, each cycle is a sequential fetch (mreq_no=0, seq_o=1). addr_o advances by 4, or by 2 when status bit 5 is set.
- R9: In the running phase, a write (wr_en_i=1) loads wr_pc_i into addr_o and wr_psr_i into the status word at the next edge. That cycle is a non-sequential fetch (seq_o=0).
- R10: A write presented during reset, the synchroniser window, the banking cycle or the first fetch cycle changes neither addr_o nor the status word.
- R11: lr_svc_o and spsr_svc_o change only at the end of a banking cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low core reset, asynchronous assert |
| wr_en_i | input | 1 | Load PC and status word (running phase only) |
| wr_pc_i | input | 32 | PC value to load |
| wr_psr_i | input | 32 | Status word value to load |
| addr_o | output | 32 | Fetch address (current PC) |
| mreq_no | output | 1 | Memory request, active low |
| seq_o | output | 1 | Sequential-cycle flag |
| cpsr_o | output | 32 | Current status word |
| lr_svc_o | output | 32 | Supervisor link register |
| spsr_svc_o | output | 32 | Supervisor saved-status register |

## Verification
The reset cycle encoding is combinational, so the bench checks it one time unit after lowering rst_ni, before any edge. Each address step in reset and in the running phase is due at the very next rising edge, and the bench samples 2 ns after every edge. After release, the bench counts edges. The third edge must still show an incremented address with internal-cycle encoding. The fourth edge brings the banked values, the forced status byte and address 0. The fifth brings address 4 with a sequential fetch. A write lands one edge after it is presented. Ignored writes are held on wr_en_i across the reset, banking and first fetch cycles, and the address and status word are compared at each edge in that span.

// File: rtl/bes_pkg.sv
package bes_pkg;
  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_BANK  = 2'd1,
    PH_FIRST = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;

  localparam int unsigned PSR_I_BIT = 7;
  localparam int unsigned PSR_F_BIT = 6;
  localparam int unsigned PSR_T_BIT = 5;
  localparam logic [4:0]  MODE_SVC  = 5'b10011;

  // fetch step from the 16-bit state flag
  function automatic logic [2:0] fetch_step(input logic t_bit);
    return t_bit ? 3'd2 : 3'd4;
  endfunction
endpackage

// File: rtl/bes_rst_sync.sv
module bes_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rel_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rel_o = sync_q[STAGES-1];
endmodule

// File: rtl/bes_phase_fsm.sv
module bes_phase_fsm
  import bes_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rel_i,
  input  logic   wr_en_i,
  output phase_e phase_o,
  output logic   mreq_no,
  output logic   seq_o
);
  phase_e phase_q, phase_d;
  logic   jump_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_RESET: if (rel_i) phase_d = PH_BANK;
      PH_BANK:  phase_d = PH_FIRST;
      PH_FIRST: phase_d = PH_RUN;
      PH_RUN:   phase_d = PH_RUN;
      default:  phase_d = PH_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RESET;
      jump_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      jump_q  <= (phase_q == PH_RUN) && wr_en_i;
    end
  end

  // rst_ni gates the outputs so the internal-cycle code holds before any edge
  assign mreq_no = !(rst_ni && (phase_q == PH_FIRST || phase_q == PH_RUN));
  assign seq_o   = rst_ni && (phase_q == PH_RUN) && !jump_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/bes_state_bank.sv
module bes_state_bank
  import bes_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  phase_e          phase_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_pc_i,
  input  logic [XLEN-1:0] wr_psr_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] psr_o,
  output logic [XLEN-1:0] lr_o,
  output logic [XLEN-1:0] spsr_o
);
  localparam int unsigned PADW = XLEN - 3;

  logic [XLEN-1:0] pc_q, psr_q, lr_q, spsr_q;
  logic [XLEN-1:0] step, psr_forced;

  assign step = {{PADW{1'b0}}, fetch_step(psr_q[PSR_T_BIT])};

  always_comb begin
    psr_forced            = psr_q;
    psr_forced[PSR_I_BIT] = 1'b1;
    psr_forced[PSR_F_BIT] = 1'b1;
    psr_forced[PSR_T_BIT] = 1'b0;
    psr_forced[4:0]       = MODE_SVC;
  end

  // architectural state carries no reset: its value at reset is what gets banked
  always_ff @(posedge clk_i) begin
    unique case (phase_i)
      PH_RESET: pc_q <= pc_q + step;
      PH_BANK: begin
        pc_q   <= '0;
        psr_q  <= psr_forced;
        lr_q   <= pc_q;
        spsr_q <= psr_q;
      end
      PH_FIRST: pc_q <= pc_q + step;
      PH_RUN: begin
        if (wr_en_i) begin
          pc_q  <= wr_pc_i;
          psr_q <= wr_psr_i;
        end else begin
          pc_q  <= pc_q + step;
        end
      end
      default: pc_q <= pc_q;
    endcase
  end

  assign pc_o   = pc_q;
  assign psr_o  = psr_q;
  assign lr_o   = lr_q;
  assign spsr_o = spsr_q;
endmodule

// File: rtl/boot_entry_seq.sv
module boot_entry_seq
  import bes_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_pc_i,
  input  logic [XLEN-1:0] wr_psr_i,
  output logic [XLEN-1:0] addr_o,
  output logic            mreq_no,
  output logic            seq_o,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] lr_svc_o,
  output logic [XLEN-1:0] spsr_svc_o
);
  logic   rel;
  phase_e phase;

  bes_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rel_o (rel)
  );

  bes_phase_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rel_i  (rel),
    .wr_en_i(wr_en_i),
    .phase_o(phase),
    .mreq_no(mreq_no),
    .seq_o  (seq_o)
  );

  bes_state_bank #(.XLEN(XLEN)) u_bank (
    .clk_i   (clk_i),
    .phase_i (phase),
    .wr_en_i (wr_en_i),
    .wr_pc_i (wr_pc_i),
    .wr_psr_i(wr_psr_i),
    .pc_o    (addr_o),
    .psr_o   (cpsr_o),
    .lr_o    (lr_svc_o),
    .spsr_o  (spsr_svc_o)
  );
endmodule

// File: rtl/bes_checker.sv
module bes_checker
  import bes_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [XLEN-1:0] wr_pc_i,
  input logic [XLEN-1:0] wr_psr_i,
  input phase_e          phase,
  input logic [XLEN-1:0] addr_o,
  input logic            mreq_no,
  input logic            seq_o,
  input logic [XLEN-1:0] cpsr_o,
  input logic [XLEN-1:0] lr_svc_o,
  input logic [XLEN-1:0] spsr_svc_o
);
  logic [XLEN-1:0] step;
  assign step = {{(XLEN-3){1'b0}}, fetch_step(cpsr_o[PSR_T_BIT])};

  // R1
  always_comb begin
    if (!rst_ni) a_r1_internal_cycle: assert (mreq_no && !seq_o);
  end

  a_r4_sync_window_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RESET) |=> (addr_o == $past(addr_o) + $past(step)) && mreq_no);

  a_r5_banking: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BANK) |=> (lr_svc_o == $past(addr_o)) && (spsr_svc_o == $past(cpsr_o)));

  a_r6_forced_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BANK) |=> (cpsr_o[7:0] == 8'hD3) && (cpsr_o[XLEN-1:8] == $past(cpsr_o[XLEN-1:8])));

  a_r7_first_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BANK) |=> (addr_o == '0) && !mreq_no && !seq_o);

  a_r8_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_no && !(phase == PH_RUN && wr_en_i)) |=>
      (addr_o == $past(addr_o) + $past(step)) && !mreq_no && seq_o);

  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RUN && wr_en_i) |=>
      (addr_o == $past(wr_pc_i)) && (cpsr_o == $past(wr_psr_i)) && !seq_o && !mreq_no);

  a_r10_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RESET && wr_en_i) |=> $stable(cpsr_o));

  a_r11_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_BANK) |=> $stable(lr_svc_o) && $stable(spsr_svc_o));
endmodule

bind boot_entry_seq bes_checker #(.XLEN(XLEN)) u_bes_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_pc_i   (wr_pc_i),
  .wr_psr_i  (wr_psr_i),
  .phase     (phase),
  .addr_o    (addr_o),
  .mreq_no   (mreq_no),
  .seq_o     (seq_o),
  .cpsr_o    (cpsr_o),
  .lr_svc_o  (lr_svc_o),
  .spsr_svc_o(spsr_svc_o)
);

// File: tb/boot_entry_seq_tb_top.sv
module boot_entry_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_pc_i = '0;
  logic [31:0] wr_psr_i = '0;
  logic [31:0] addr_o, cpsr_o, lr_svc_o, spsr_svc_o;
  logic        mreq_no, seq_o;

  int unsigned errors = 0;
  int unsigned checks = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  boot_entry_seq dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_pc_i   (wr_pc_i),
    .wr_psr_i  (wr_psr_i),
    .addr_o    (addr_o),
    .mreq_no   (mreq_no),
    .seq_o     (seq_o),
    .cpsr_o    (cpsr_o),
    .lr_svc_o  (lr_svc_o),
    .spsr_svc_o(spsr_svc_o)
  );

  function automatic logic [31:0] step_of(input logic [31:0] psr);
    return psr[5] ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] forced_psr(input logic [31:0] psr);
    return {psr[31:8], 1'b1, 1'b1, 1'b0, 5'b10011};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    logic [31:0] pc_w, psr_w, a, lr_prev, junk;
    int unsigned n;
    void'($urandom(32'h5EED_0042));

    // R1: internal-cycle code at time zero, before any edge
    #1;
    chk(mreq_no === 1'b1 && seq_o === 1'b0, "R1", {30'd0, mreq_no, seq_o}, 32'h2);
    tick; tick; tick;
    chk(mreq_no === 1'b1 && seq_o === 1'b0, "R1", {30'd0, mreq_no, seq_o}, 32'h2);

    // first release from power-up
    rst_ni = 1'b1;
    tick; tick; tick;
    chk(mreq_no === 1'b1 && seq_o === 1'b0, "R4", {30'd0, mreq_no, seq_o}, 32'h2);
    tick;
    chk(addr_o === 32'd0 && mreq_no === 1'b0 && seq_o === 1'b0, "R7", addr_o, 32'd0);
    chk(cpsr_o[7:0] === 8'hD3, "R6", {24'd0, cpsr_o[7:0]}, 32'hD3);
    tick;
    chk(addr_o === 32'd4 && seq_o === 1'b1 && mreq_no === 1'b0, "R8", addr_o, 32'd4);

    for (int r = 0; r < 24; r++) begin
      pc_w  = $urandom;
      psr_w = $urandom;
      psr_w[5] = r[0];
      if (r == 2) pc_w = 32'hFFFF_FFFE;   // wrap corner
      lr_prev = lr_svc_o;

      // R9: write in running phase
      wr_en_i = 1'b1; wr_pc_i = pc_w; wr_psr_i = psr_w;
      tick;
      wr_en_i = 1'b0;
      chk(addr_o === pc_w, "R9", addr_o, pc_w);
      chk(cpsr_o === psr_w, "R9", cpsr_o, psr_w);
      chk(seq_o === 1'b0 && mreq_no === 1'b0, "R9", {30'd0, mreq_no, seq_o}, 32'h0);
      a = pc_w + step_of(psr_w);
      tick;
      chk(addr_o === a && seq_o === 1'b1, "R8", addr_o, a);
      chk(lr_svc_o === lr_prev, "R11", lr_svc_o, lr_prev);

      // reset entry, with a write held on throughout
      rst_ni = 1'b0;
      junk = $urandom;
      wr_en_i = 1'b1; wr_pc_i = junk; wr_psr_i = ~junk;
      #1;
      chk(mreq_no === 1'b1 && seq_o === 1'b0, "R1", {30'd0, mreq_no, seq_o}, 32'h2);
      chk(addr_o === a, "R1", addr_o, a);
      n = 1 + ($urandom % 4);
      for (int k = 0; k < int'(n); k++) begin
        tick;
        a = a + step_of(psr_w);
        chk(addr_o === a, psr_w[5] ? "R3" : "R2", addr_o, a);
        chk(cpsr_o === psr_w, "R10", cpsr_o, psr_w);
      end

      // release: three stepping edges then banking cycle
      rst_ni = 1'b1;
      for (int k = 0; k < 3; k++) begin
        tick;
        a = a + step_of(psr_w);
        chk(addr_o === a && mreq_no === 1'b1 && seq_o === 1'b0, "R4", addr_o, a);
        chk(cpsr_o === psr_w, "R10", cpsr_o, psr_w);
      end
      tick;
      chk(lr_svc_o === a, "R5", lr_svc_o, a);
      chk(spsr_svc_o === psr_w, "R5", spsr_svc_o, psr_w);
      chk(cpsr_o === forced_psr(psr_w), "R6", cpsr_o, forced_psr(psr_w));
      chk(addr_o === 32'd0 && mreq_no === 1'b0 && seq_o === 1'b0, "R7", addr_o, 32'd0);
      tick;
      wr_en_i = 1'b0;
      chk(addr_o === 32'd4 && seq_o === 1'b1, "R10", addr_o, 32'd4);
      chk(cpsr_o === forced_psr(psr_w), "R10", cpsr_o, forced_psr(psr_w));
      chk(lr_svc_o === a, "R11", lr_svc_o, a);
      tick;
      chk(addr_o === 32'd8 && seq_o === 1'b1 && mreq_no === 1'b0, "R8", addr_o, 32'd8);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule